// File: doc/BRIEF.md
# Periodic Temperature Result Updater

This block turns a stream of averaged raw temperature samples into a corrected result that refreshes at a fixed rate. An upstream converter pulses `sampleStb` once per conversion and presents its averaged reading on `rawTemp`. The block counts these pulses. When a full window of `WINDOW` pulses has been counted (2240 by default), it adds a programmable signed offset to the raw reading, scales the sum by a programmable unsigned gain, and saturates the product into a 24-bit result register. On the same edge it raises a sticky update flag.

Software reaches the block through two ports. A write port sets the offset, the gain, the clock-divider setting K and the cycle count. A combinational read port returns the result, the status bits, K or the cycle count. A dedicated `clrFlag` input drops the update flag.

A cycle count below two is an invalid setting. While it is in place, the block reports the fault and makes no updates. Writing K restarts the window, so that a partly counted window is thrown away.

Top module: `temp_result_updater`

## Requirements
- R1: The result register and the update flag are loaded only on a clock edge where `sampleStb` is high and that strobe completes a window of `WINDOW` counted strobes. Cycles without a strobe do not advance the count, and the first window after reset ends on the `WINDOW`-th strobe.
- R2: On an update, the result equals floor((raw + offset) × gain / 2^24), where raw and offset are signed Q1.23, gain is unsigned Q7.17 and the result is signed Q8.16. The raw value used is the one present with the strobe that completes the window.
- R3: A corrected value above 0x7FFFFF is stored as 0x7FFFFF, and one below -2^23 is stored as 0x800000.
- R4: Status bit 0 (the update flag) goes to 1 on every update and stays at 1 until `clrFlag` is high on an edge with no update. An update on the same edge as a clear leaves the flag at 1.
- R5: While the cycle count is 0 or 1, status bit 1 reads 1, no update occurs, and the window count is held at zero. Once a valid count is written, a full window is needed before the next update.
- R6: A write to write-address 2 (K) stores the value and restarts the window at zero. A strobe on the same edge is not counted and cannot complete a window.
- R7: After reset the result and the status read 0, K reads 1, the cycle count reads 4000, the offset is 0 and the gain is 1.0 (0x020000).
- R8: The write addresses are 0 offset, 1 gain, 2 K and 3 cycle count. `rdSel` 0 returns the result, 1 the status (bit 0 flag, bit 1 bad-cycle-count, all other bits 0), 2 K and 3 the cycle count.
- R9: Between updates the result holds its value. Offset and gain writes take effect only at the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One pulse per converter sample |
| rawTemp | input | 24 | Averaged raw temperature, signed Q1.23 |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Write address (0 offset, 1 gain, 2 K, 3 cycle count) |
| wrData | input | 24 | Write data |
| clrFlag | input | 1 | Clears the update flag |
| rdSel | input | 2 | Read select (0 result, 1 status, 2 K, 3 cycle count) |
| rdData | output | 24 | Read data |

## Verification
The hardest cases to reach are the ones where two events fall on the same edge as the strobe that closes a window: a flag clear, or a write to K. With the real window of 2240 samples, these edges come up only rarely. The bench therefore shrinks the window to four strobes, counts strobes itself, and places the clear or the K write exactly on the fourth strobe. It then sweeps raw, offset and gain values, including both extremes, through full windows and checks each result against an independently computed integer expression.

// File: rtl/tru_pkg.sv
package tru_pkg;
  typedef enum logic [1:0] {
    WA_OFFSET = 2'd0,
    WA_GAIN   = 2'd1,
    WA_KDIV   = 2'd2,
    WA_CYCLES = 2'd3
  } wrAddr_e;

  typedef enum logic [1:0] {
    RS_RESULT = 2'd0,
    RS_STATUS = 2'd1,
    RS_KDIV   = 2'd2,
    RS_CYCLES = 2'd3
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic update;
    logic loadOffset;
    logic loadGain;
  } ctlStrobe_t;
endpackage

// File: rtl/tru_ctrl.sv
module tru_ctrl
  import tru_pkg::*;
#(
  parameter int WINDOW     = 2240,
  parameter int DATA_W     = 24,
  parameter int DEF_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrFlag,
  output ctlStrobe_t        ctl,
  output logic [DATA_W-1:0] kDivQ,
  output logic [DATA_W-1:0] cyclesQ,
  output logic              updFlag,
  output logic              cfgErr
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] cntQ;
  logic wrK, wrCycles, wrap;

  always_comb begin
    wrK            = wrEn && (wrAddr == WA_KDIV);
    wrCycles       = wrEn && (wrAddr == WA_CYCLES);
    cfgErr         = cyclesQ < DATA_W'(2);
    wrap           = sampleStb && (cntQ == LAST);
    ctl.update     = wrap && !cfgErr && !wrK;
    ctl.loadOffset = wrEn && (wrAddr == WA_OFFSET);
    ctl.loadGain   = wrEn && (wrAddr == WA_GAIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      kDivQ   <= DATA_W'(1);
      cyclesQ <= DATA_W'(DEF_CYCLES);
      updFlag <= 1'b0;
    end else begin
      if (wrK || cfgErr)   cntQ <= '0;
      else if (sampleStb)  cntQ <= wrap ? '0 : cntQ + 1'b1;
      if (wrK)             kDivQ   <= wrData;
      if (wrCycles)        cyclesQ <= wrData;
      if (ctl.update)      updFlag <= 1'b1;
      else if (clrFlag)    updFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tru_datapath.sv
module tru_datapath
  import tru_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int FRAC_DROP = 24,
  parameter logic [DATA_W-1:0] DEF_GAIN = 24'h020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] rawTemp,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] resultQ
);
  localparam int SUM_W  = DATA_W + 1;
  localparam int PROD_W = 2 * SUM_W;
  localparam int HEAD_W = PROD_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]        offsetQ, gainQ, satVal;
  logic signed [SUM_W-1:0]  sum, gainExt;
  logic signed [PROD_W-1:0] prod, shifted;
  logic [HEAD_W-1:0]        head;

  always_comb begin
    sum     = $signed({rawTemp[DATA_W-1], rawTemp}) + $signed({offsetQ[DATA_W-1], offsetQ});
    gainExt = $signed({1'b0, gainQ});
    prod    = sum * gainExt;
    shifted = prod >>> FRAC_DROP;
    head    = shifted[PROD_W-1:DATA_W-1];
    if ((&head) || !(|head)) satVal = shifted[DATA_W-1:0];
    else                     satVal = head[HEAD_W-1] ? MIN_V : MAX_V;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      gainQ   <= DEF_GAIN;
      resultQ <= '0;
    end else begin
      if (ctl.loadOffset) offsetQ <= wrData;
      if (ctl.loadGain)   gainQ   <= wrData;
      if (ctl.update)     resultQ <= satVal;
    end
  end
endmodule

// File: rtl/temp_result_updater.sv
module temp_result_updater
  import tru_pkg::*;
#(
  parameter int WINDOW     = 2240,
  parameter int DATA_W     = 24,
  parameter int DEF_CYCLES = 4000,
  parameter int FRAC_DROP  = 24,
  parameter logic [DATA_W-1:0] DEF_GAIN = 24'h020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [DATA_W-1:0] rawTemp,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrFlag,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobe_t        ctl;
  logic [DATA_W-1:0] kDivQ, cyclesQ, resultQ;
  logic              updFlag, cfgErr, updatePulse;

  assign updatePulse = ctl.update;

  tru_ctrl #(.WINDOW(WINDOW), .DATA_W(DATA_W), .DEF_CYCLES(DEF_CYCLES)) ctrlI (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .clrFlag(clrFlag), .ctl(ctl), .kDivQ(kDivQ), .cyclesQ(cyclesQ),
    .updFlag(updFlag), .cfgErr(cfgErr)
  );

  tru_datapath #(.DATA_W(DATA_W), .FRAC_DROP(FRAC_DROP), .DEF_GAIN(DEF_GAIN)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rawTemp(rawTemp), .wrData(wrData), .resultQ(resultQ)
  );

  always_comb begin
    unique case (rdSel)
      RS_RESULT: rdData = resultQ;
      RS_STATUS: rdData = {{(DATA_W-2){1'b0}}, cfgErr, updFlag};
      RS_KDIV:   rdData = kDivQ;
      default:   rdData = cyclesQ;
    endcase
  end
endmodule

// File: rtl/tru_chk.sv
module tru_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStb,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic              clrFlag,
  input logic              update,
  input logic              updFlag,
  input logic              cfgErr,
  input logic [DATA_W-1:0] resultQ
);
  // R1
  update_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    update |-> sampleStb);
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    update |=> updFlag);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !clrFlag) |=> updFlag);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !update) |=> !updFlag);
  // R5
  no_update_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !update);
  // R6
  restart_blocks_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2) |-> !update);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !update |=> $stable(resultQ));
endmodule

bind temp_result_updater tru_chk #(.DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .wrEn(wrEn), .wrAddr(wrAddr),
  .clrFlag(clrFlag), .update(updatePulse), .updFlag(updFlag), .cfgErr(cfgErr),
  .resultQ(resultQ)
);

// File: tb/temp_result_updater_test.sv
module temp_result_updater_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [23:0] rawTemp = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic        clrFlag = 1'b0;
  logic [1:0]  rdSel = '0;
  logic [23:0] rdData;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  temp_result_updater #(.WINDOW(4)) uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .rawTemp(rawTemp), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .clrFlag(clrFlag), .rdSel(rdSel), .rdData(rdData)
  );

  function automatic logic [23:0] model(input logic [23:0] r, input logic [23:0] o,
                                        input logic [23:0] g);
    longint s, p, q;
    s = longint'($signed(r)) + longint'($signed(o));
    p = s * longint'(g);
    q = p >>> 24;
    if (q > 64'sd8388607)  return 24'h7FFFFF;
    if (q < -64'sd8388608) return 24'h800000;
    return q[23:0];
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [23:0] v);
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic strobe(input logic [23:0] v);
    @(negedge clk); sampleStb = 1'b1; rawTemp = v;
    @(negedge clk); sampleStb = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); clrFlag = 1'b1;
    @(negedge clk); clrFlag = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [23:0] v, last;
    logic [23:0] offs [4];
    logic [23:0] gains [4];
    offs[0] = 24'h000000; offs[1] = 24'hF3C168; offs[2] = 24'h7FFFFF; offs[3] = 24'h800000;
    gains[0] = 24'h020000; gains[1] = 24'h2F0000; gains[2] = 24'h549999; gains[3] = 24'hFFFFFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 / R8: reset state through the read map
    rd(2'd0, v); check("R7 result", v, 24'h0);
    rd(2'd1, v); check("R7 status", v, 24'h0);
    rd(2'd2, v); check("R8 K", v, 24'd1);
    rd(2'd3, v); check("R8 cycles", v, 24'd4000);
    // R7: default gain 1.0 and zero offset
    repeat (3) strobe(24'h123456);
    strobe(24'h400000);
    rd(2'd0, v); check("R7 default correction", v, model(24'h400000, 24'h0, 24'h020000));
    clr();

    // R2 / R3 / R4: sweep of offset, gain and raw
    for (int o = 0; o < 4; o++) begin
      for (int g = 0; g < 4; g++) begin
        wr(2'd0, offs[o]);
        wr(2'd1, gains[g]);
        for (int r = 0; r < 12; r++) begin
          logic [23:0] raw;
          if (r == 0)      raw = 24'h800000;
          else if (r == 1) raw = 24'h7FFFFF;
          else if (r == 2) raw = 24'h000000;
          else             raw = 24'((r * 32'h1D3A5B) ^ (r << 19));
          repeat (3) strobe(~raw);
          strobe(raw);
          rd(2'd0, v); check("R2 corrected result", v, model(raw, offs[o], gains[g]));
          rd(2'd1, v); check("R4 flag set", v, 24'h1);
          clr();
          rd(2'd1, v); check("R4 flag cleared", v, 24'h0);
        end
      end
    end

    // R3: explicit saturation
    wr(2'd0, 24'h7FFFFF); wr(2'd1, 24'hFFFFFF);
    repeat (4) strobe(24'h7FFFFF);
    rd(2'd0, v); check("R3 positive clamp", v, 24'h7FFFFF);
    wr(2'd0, 24'h800000);
    repeat (4) strobe(24'h800000);
    rd(2'd0, v); check("R3 negative clamp", v, 24'h800000);
    clr();

    // R1: gaps between strobes do not count
    wr(2'd0, 24'hF3C168); wr(2'd1, 24'h2F0000);
    rd(2'd0, last);
    for (int i = 0; i < 3; i++) begin
      strobe(24'h0A0000);
      repeat (3) @(negedge clk);
    end
    rd(2'd1, v); check("R1 no update before window end", v, 24'h0);
    rd(2'd0, v); check("R1 result unchanged mid window", v, last);
    strobe(24'h0B0000);
    rd(2'd1, v); check("R1 update at window end", v, 24'h1);
    rd(2'd0, v); check("R1 raw from final strobe", v, model(24'h0B0000, 24'hF3C168, 24'h2F0000));

    // R9: offset write mid-window changes nothing until next update
    last = v;
    wr(2'd0, 24'h010000);
    rd(2'd0, v); check("R9 result holds after offset write", v, last);
    repeat (3) strobe(24'h0B0000);
    rd(2'd0, v); check("R9 result holds mid window", v, last);
    strobe(24'h0B0000);
    rd(2'd0, v); check("R9 new offset used", v, model(24'h0B0000, 24'h010000, 24'h2F0000));

    // R4: clear coinciding with window end keeps the flag
    repeat (3) strobe(24'h0);
    @(negedge clk); sampleStb = 1'b1; clrFlag = 1'b1; rawTemp = 24'h0;
    @(negedge clk); sampleStb = 1'b0; clrFlag = 1'b0;
    rd(2'd1, v); check("R4 update beats clear", v, 24'h1);
    clr();
    rd(2'd1, v); check("R4 clear alone", v, 24'h0);

    // R6: K write restarts window
    repeat (2) strobe(24'h0);
    wr(2'd2, 24'd5);
    rd(2'd2, v); check("R6 K stored", v, 24'd5);
    repeat (3) strobe(24'h0);
    rd(2'd1, v); check("R6 partial window discarded", v, 24'h0);
    strobe(24'h0);
    rd(2'd1, v); check("R6 update after full new window", v, 24'h1);
    clr();
    // R6: K write on the completing strobe
    repeat (3) strobe(24'h0);
    @(negedge clk); sampleStb = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 24'd7;
    @(negedge clk); sampleStb = 1'b0; wrEn = 1'b0;
    rd(2'd1, v); check("R6 restart beats completing strobe", v, 24'h0);
    repeat (3) strobe(24'h0);
    rd(2'd1, v); check("R6 strobe on restart edge not counted", v, 24'h0);
    strobe(24'h0);
    rd(2'd1, v); check("R6 window after coincident restart", v, 24'h1);
    clr();

    // R5: invalid cycle count
    wr(2'd3, 24'd1);
    rd(2'd1, v); check("R5 bad count flagged (1)", v, 24'h2);
    rd(2'd0, last);
    repeat (8) strobe(24'h300000);
    rd(2'd1, v); check("R5 no update while invalid", v, 24'h2);
    rd(2'd0, v); check("R5 result unchanged while invalid", v, last);
    wr(2'd3, 24'd0);
    rd(2'd1, v); check("R5 bad count flagged (0)", v, 24'h2);
    strobe(24'h300000);
    wr(2'd3, 24'd2);
    rd(2'd3, v); check("R8 cycles readback", v, 24'd2);
    rd(2'd1, v); check("R5 valid count clears fault", v, 24'h0);
    repeat (3) strobe(24'h300000);
    rd(2'd1, v); check("R5 counter held at zero", v, 24'h0);
    strobe(24'h300000);
    rd(2'd1, v); check("R5 update resumes", v, 24'h1);
    rd(2'd0, v); check("R5 result after resume", v, model(24'h300000, 24'h010000, 24'h2F0000));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule